// File: doc/BRIEF.md
# Pause-loop exit detector

This block watches the pause events a guest issues and decides, per event, whether the event must end guest execution with an exit. There are two ways to trip it. A blunt control makes every pause exit. A finer control detects spin loops from timing. Each pause carries a timestamp from a free-running counter. Pauses that arrive close together are grouped into one loop. Once a loop has lasted longer than a programmed window, the next pause in it is sent out as an exit.

The block stores two timestamps: the start of the current loop and the most recent pause. Two thresholds drive the loop check. The gap threshold decides whether a pause still belongs to the running loop. The window threshold decides when that loop has run too long. An exit request comes out as a one-cycle pulse, one clock after the pause strobe. The pulse carries a fixed pause reason code and an all-zero qualification. The exit sequence that follows is handled elsewhere.

Top module: `ple_exit_detect`

## Requirements
- R1: When `pause_exit_all_i` is 1, every pause strobe gives an exit pulse on the next cycle, whatever the privilege level and the loop control are.
- R2: Loop tracking takes part only when `pause_loop_en_i` is 1 and `cpl_i` is 0. Any other pause without the all-exit control gives no exit and leaves both stored timestamps unchanged.
- R3: For a tracked pause, if (now − last pause time) is greater than the gap threshold, a new loop starts. The loop-start time is loaded with now, and that pause gives no exit.
- R4: For a tracked pause that does not start a new loop, an exit is raised when (now − loop-start time) is greater than the window threshold.
- R5: Every tracked pause writes now into the last-pause time, including a pause that raises an exit.
- R6: With an exit pulse, `reason_o` carries the pause reason code (parameter `PAUSE_CODE`, default 40). At all other times `reason_o` is 0, and `qual_o` is always 0.
- R7: Time differences are unsigned and taken modulo 2^TS_W, so a timestamp that wraps past zero still gives the correct elapsed time.
- R8: A difference exactly equal to a threshold does not exceed it.
- R9: Reset clears both stored timestamps to 0 and clears all outputs. `exit_o` is high only in the cycle after a pause strobe that requested an exit.
- R10: A pause that exits because of the all-exit control leaves both stored timestamps unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pause_i | input | 1 | One strobe per guest pause event |
| tstamp_i | input | TS_W | Current free-running time |
| cpl_i | input | CPL_W | Current privilege level |
| pause_exit_all_i | input | 1 | Exit on every pause |
| pause_loop_en_i | input | 1 | Enable spin-loop detection |
| gap_thr_i | input | TS_W | Largest spacing allowed between pauses of one loop |
| win_thr_i | input | TS_W | Longest a loop may run before it exits |
| exit_o | output | 1 | Exit request pulse |
| reason_o | output | REASON_W | Exit reason code |
| qual_o | output | QUAL_W | Exit qualification, always zero |

## Verification
The bench builds the block with TS_W = 16 and keeps the other defaults. The narrow timestamp lets a loop straddle the wrap from 65535 to 0 in a few pauses, which exercises the modular arithmetic without long runs. With a gap of 100 and a window of 1000, equality at both thresholds can be hit exactly. Pauses at privilege 3, pauses with loop detection off and pauses under the all-exit control are each followed by timed probes. Those probes only pass if the stored loop-start time was left alone.

// File: rtl/ple_pkg.sv
package ple_pkg;

  localparam int unsigned PAUSE_CODE_DEF = 40;

  // outcome of one pause strobe
  typedef enum logic [1:0] {
    PLE_NONE  = 2'd0,  // no strobe, or strobe not tracked
    PLE_START = 2'd1,  // tracked, opens a new loop
    PLE_HOLD  = 2'd2,  // tracked, loop continues within window
    PLE_TRIP  = 2'd3   // exit requested
  } ple_verdict_e;

endpackage

// File: rtl/ple_span_cmp.sv
module ple_span_cmp #(
  parameter int unsigned TS_W = 64
) (
  input  logic [TS_W-1:0] now_i,
  input  logic [TS_W-1:0] ref_i,
  input  logic [TS_W-1:0] thr_i,
  output logic            over_o
);
  logic [TS_W-1:0] span;

  // modular difference: wrap of the time base is absorbed here
  always_comb begin
    span   = now_i - ref_i;
    over_o = span > thr_i;
  end
endmodule

// File: rtl/ple_tracker.sv
module ple_tracker #(
  parameter int unsigned TS_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic            restart_i,
  input  logic [TS_W-1:0] now_i,
  output logic [TS_W-1:0] first_o,
  output logic [TS_W-1:0] last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_o <= '0;
      last_o  <= '0;
    end else if (upd_i) begin
      last_o <= now_i;
      if (restart_i) first_o <= now_i;
    end
  end
endmodule

// File: rtl/ple_exit_out.sv
module ple_exit_out #(
  parameter int unsigned REASON_W   = 16,
  parameter int unsigned PAUSE_CODE = 40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  output logic                exit_o,
  output logic [REASON_W-1:0] reason_o
);
  localparam logic [REASON_W-1:0] CODE = REASON_W'(PAUSE_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exit_o   <= 1'b0;
      reason_o <= '0;
    end else begin
      exit_o   <= req_i;
      reason_o <= req_i ? CODE : '0;
    end
  end
endmodule

// File: rtl/ple_exit_detect.sv
module ple_exit_detect #(
  parameter int unsigned TS_W       = 64,
  parameter int unsigned CPL_W      = 2,
  parameter int unsigned REASON_W   = 16,
  parameter int unsigned QUAL_W     = 64,
  parameter int unsigned PAUSE_CODE = ple_pkg::PAUSE_CODE_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pause_i,
  input  logic [TS_W-1:0]     tstamp_i,
  input  logic [CPL_W-1:0]    cpl_i,
  input  logic                pause_exit_all_i,
  input  logic                pause_loop_en_i,
  input  logic [TS_W-1:0]     gap_thr_i,
  input  logic [TS_W-1:0]     win_thr_i,
  output logic                exit_o,
  output logic [REASON_W-1:0] reason_o,
  output logic [QUAL_W-1:0]   qual_o
);
  import ple_pkg::*;

  logic [TS_W-1:0] first_ts, last_ts;
  logic            gap_over, win_over;
  logic            tracked;
  ple_verdict_e    verdict;

  ple_span_cmp #(.TS_W(TS_W)) u_gap (
    .now_i (tstamp_i),
    .ref_i (last_ts),
    .thr_i (gap_thr_i),
    .over_o(gap_over)
  );

  ple_span_cmp #(.TS_W(TS_W)) u_win (
    .now_i (tstamp_i),
    .ref_i (first_ts),
    .thr_i (win_thr_i),
    .over_o(win_over)
  );

  // all-exit control takes precedence and bypasses loop tracking
  always_comb begin
    tracked = pause_i && !pause_exit_all_i && pause_loop_en_i && (cpl_i == '0);
    verdict = PLE_NONE;
    if (pause_i && pause_exit_all_i) verdict = PLE_TRIP;
    else if (tracked) begin
      if (gap_over)      verdict = PLE_START;
      else if (win_over) verdict = PLE_TRIP;
      else               verdict = PLE_HOLD;
    end
  end

  ple_tracker #(.TS_W(TS_W)) u_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (tracked),
    .restart_i(verdict == PLE_START),
    .now_i    (tstamp_i),
    .first_o  (first_ts),
    .last_o   (last_ts)
  );

  ple_exit_out #(.REASON_W(REASON_W), .PAUSE_CODE(PAUSE_CODE)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (verdict == PLE_TRIP),
    .exit_o  (exit_o),
    .reason_o(reason_o)
  );

  assign qual_o = '0;
endmodule

// File: rtl/ple_exit_detect_chk.sv
module ple_exit_detect_chk #(
  parameter int unsigned TS_W       = 64,
  parameter int unsigned CPL_W      = 2,
  parameter int unsigned REASON_W   = 16,
  parameter int unsigned QUAL_W     = 64,
  parameter int unsigned PAUSE_CODE = 40
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                pause_i,
  input logic [TS_W-1:0]     tstamp_i,
  input logic [CPL_W-1:0]    cpl_i,
  input logic                pause_exit_all_i,
  input logic                pause_loop_en_i,
  input logic [TS_W-1:0]     gap_thr_i,
  input logic [TS_W-1:0]     win_thr_i,
  input logic                exit_o,
  input logic [REASON_W-1:0] reason_o,
  input logic [QUAL_W-1:0]   qual_o
);
  localparam logic [REASON_W-1:0] CODE = REASON_W'(PAUSE_CODE);

  logic unused_in;
  assign unused_in = ^{tstamp_i, gap_thr_i, win_thr_i};

  assert_all_exit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i && pause_exit_all_i |=> exit_o);

  assert_untracked_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i && !pause_exit_all_i && (!pause_loop_en_i || cpl_i != '0) |=> !exit_o);

  assert_reason_on_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |-> reason_o == CODE);

  assert_reason_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exit_o |-> reason_o == '0);

  assert_qual_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |-> qual_o == '0);

  assert_no_strobe_no_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_i |=> !exit_o);
endmodule

bind ple_exit_detect ple_exit_detect_chk #(
  .TS_W(TS_W), .CPL_W(CPL_W), .REASON_W(REASON_W), .QUAL_W(QUAL_W), .PAUSE_CODE(PAUSE_CODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pause_i(pause_i), .tstamp_i(tstamp_i), .cpl_i(cpl_i),
  .pause_exit_all_i(pause_exit_all_i), .pause_loop_en_i(pause_loop_en_i),
  .gap_thr_i(gap_thr_i), .win_thr_i(win_thr_i),
  .exit_o(exit_o), .reason_o(reason_o), .qual_o(qual_o)
);

// File: tb/ple_exit_detect_test.sv
module ple_exit_detect_test;
  localparam int unsigned TS_W = 16;
  localparam int unsigned CPL_W = 2;
  localparam int unsigned REASON_W = 16;
  localparam int unsigned QUAL_W = 64;
  localparam int unsigned CODE = 40;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                pause_i = 1'b0;
  logic [TS_W-1:0]     tstamp_i = '0;
  logic [CPL_W-1:0]    cpl_i = '0;
  logic                pause_exit_all_i = 1'b0;
  logic                pause_loop_en_i = 1'b1;
  logic [TS_W-1:0]     gap_thr_i = 16'd100;
  logic [TS_W-1:0]     win_thr_i = 16'd1000;
  logic                exit_o;
  logic [REASON_W-1:0] reason_o;
  logic [QUAL_W-1:0]   qual_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_on  = 0;

  // model state, built from the requirements
  logic [TS_W-1:0] m_first = '0, m_last = '0;

  typedef struct { bit ex; string tag; } exp_t;
  exp_t exp_q[$];

  always #2 clk_i = ~clk_i;  // 250 MHz

  ple_exit_detect #(.TS_W(TS_W), .CPL_W(CPL_W), .REASON_W(REASON_W),
                    .QUAL_W(QUAL_W), .PAUSE_CODE(CODE)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pause_i(pause_i), .tstamp_i(tstamp_i),
    .cpl_i(cpl_i), .pause_exit_all_i(pause_exit_all_i), .pause_loop_en_i(pause_loop_en_i),
    .gap_thr_i(gap_thr_i), .win_thr_i(win_thr_i),
    .exit_o(exit_o), .reason_o(reason_o), .qual_o(qual_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: one strobe, model expectation pushed to the scoreboard
  task automatic pause_at(input int ts, input bit all, input bit en,
                          input int cpl, input string tag);
    exp_t e;
    logic [TS_W-1:0] now;
    logic [TS_W-1:0] dg, dw;
    @(negedge clk_i);
    now = TS_W'(ts);
    tstamp_i = now; pause_exit_all_i = all; pause_loop_en_i = en;
    cpl_i = CPL_W'(cpl); pause_i = 1'b1;
    e.tag = tag; e.ex = 0;
    if (all) e.ex = 1;
    else if (en && cpl == 0) begin
      dg = now - m_last;
      dw = now - m_first;
      if (dg > gap_thr_i) m_first = now;
      else e.ex = (dw > win_thr_i);
      m_last = now;
    end
    exp_q.push_back(e);
    @(negedge clk_i);
    pause_i = 1'b0;
  endtask

  task automatic steps(input int from, input int to, input int stp, input string tag);
    for (int t = from; t <= to; t += stp) pause_at(t, 0, 1, 0, tag);
  endtask

  // monitor: compares each cycle one unit after the edge
  always @(posedge clk_i) begin
    bit strobed;
    strobed = pause_i;
    #1;
    if (mon_on) begin
      if (strobed) begin
        exp_t e;
        if (exp_q.size() == 0) check(0, "R9", "queue empty", 0, 1);
        else begin
          e = exp_q.pop_front();
          check(exit_o == e.ex, e.tag, "exit_o", exit_o, e.ex);
          check(reason_o == (e.ex ? CODE : 0), "R6", "reason_o", reason_o, e.ex ? CODE : 0);
          check(qual_o == 0, "R6", "qual_o", qual_o, 0);
        end
      end else begin
        check(exit_o == 1'b0, "R9", "idle exit_o", exit_o, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(exit_o == 0, "R9", "reset exit_o", exit_o, 0);
    check(reason_o == 0, "R9", "reset reason_o", reason_o, 0);
    check(qual_o == 0, "R9", "reset qual_o", qual_o, 0);
    rst_ni = 1'b1;
    mon_on = 1;
    // R9: stored times start at 0, loop from 0 trips once past 1000 (R8 equality at 1000)
    steps(100, 1000, 100, "R9");
    pause_at(1100, 0, 1, 0, "R4");
    pause_at(1150, 0, 1, 0, "R5");      // still in loop, exits again
    // R3: gap 101 starts a new loop, no exit
    pause_at(1251, 0, 1, 0, "R3");
    pause_at(1351, 0, 1, 0, "R8");      // gap exactly 100: same loop
    steps(1451, 2251, 100, "R8");       // window exactly 1000 at 2251
    pause_at(2252, 0, 1, 0, "R4");      // 1001 > window
    // R2: privilege 3 and disabled loop detection must not move stored times
    pause_at(5000, 0, 1, 0, "R3");      // new loop, first=5000
    pause_at(5080, 0, 1, 3, "R2");
    pause_at(5160, 0, 0, 0, "R2");
    pause_at(5190, 0, 1, 0, "R2");      // gap 190 from 5000: new loop first=5190
    steps(5290, 6190, 100, "R2");       // would exit if first stayed 5000
    pause_at(6191, 0, 1, 0, "R2");
    // R1 and R10: all-exit pauses exit at any level and leave state alone
    pause_at(9000, 0, 1, 0, "R3");
    pause_at(9050, 1, 1, 3, "R1");
    pause_at(9100, 1, 0, 0, "R1");
    pause_at(9180, 1, 1, 0, "R10");
    pause_at(9190, 0, 1, 0, "R10");     // gap 190 from 9000: new loop
    steps(9290, 10190, 100, "R10");
    pause_at(10191, 0, 1, 0, "R10");
    // R7: loop straddles the wrap of the 16-bit time base
    pause_at(65000, 0, 1, 0, "R7");
    for (int k = 1; k <= 10; k++) pause_at((65000 + 100 * k) % 65536, 0, 1, 0, "R7");
    pause_at((66001) % 65536, 0, 1, 0, "R7");
    pause_at(40000, 0, 1, 0, "R7");     // far away: new loop
    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule